// File: doc/BRIEF.md
# ADC Test Bus Output Multiplexer

This block shares one narrow test output bus between the kinds of traffic needed to test a multi-step ADC. The first kind is the full-resolution conversion word with its two out-of-range flags. The second is the raw codes of the three sub-converters: coarse, mid and fine. The third is the digital scan traffic. A two-bit select picks what the bus carries. The bus bits are registered, so the new selection shows on the bus one clock edge after it is presented.

The same bus width also runs in the other direction. The incoming test bus feeds the scan-chain inputs bit for bit, and only while the registered mode is the scan mode. In every other mode the scan inputs are held at zero, so ADC test stimulus on the shared pins cannot reach the scan logic. The analog converters, the clock source and the scan chains sit outside this block.

Top module: `tbmux_top`

## Requirements
- R1: While reset is asserted (synchronous, active low), the output bus is zero from the first clock edge on. The scan-chain inputs are zero from that edge on as well.
- R2: With select 2'b00 (idle) sampled at a clock edge, the output bus is all zeros after that edge.
- R3: With select 2'b01 (full result) sampled at an edge, the output bus after that edge holds {overflow, underflow, result[11:0]}. Overflow is bit 13, underflow is bit 12, and the result occupies bits 11:0.
- R4: With select 2'b10 (sub-converter codes) sampled at an edge, the output bus after that edge holds {coarse[3:0], mid[3:0], fine[5:0]}. Coarse is in bits 13:10, mid in bits 9:6 and fine in bits 5:0.
- R5: With select 2'b11 (scan) sampled at an edge, output bus bit i after that edge equals scan-chain output bit i, for every bit.
- R6: The output bus depends only on the select and data sampled at the most recent edge. A change of select between edges does not alter the bus until the next edge, and back-to-back select changes take effect on consecutive edges.
- R7: Scan-chain input bit i equals incoming test bus bit i whenever the mode registered at the last edge is 2'b11. Otherwise all scan inputs are zero. A new select value does not open or close this path before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Bus mode select (00 idle, 01 full result, 10 sub-converter codes, 11 scan) |
| conv_result | input | 12 | Full conversion word |
| under_flag | input | 1 | Input below range |
| over_flag | input | 1 | Input above range |
| coarse_code | input | 4 | Coarse sub-converter code |
| mid_code | input | 4 | Mid sub-converter code |
| fine_code | input | 6 | Fine sub-converter code |
| chain_out | input | 14 | Scan-chain output bits from the logic under test |
| tbus_in | input | 14 | Incoming test bus |
| tbus_out | output | 14 | Registered outgoing test bus |
| chain_in | output | 14 | Scan-chain input bits to the logic under test |

## Verification
The bench builds the block with its default widths: a 12-bit result, 4/4/6-bit sub-codes and a 14-bit bus. With these widths each packed field fills the bus exactly, so a bit placed one position off shows up in both the flag bits and the sub-code boundaries. The stimulus walks single ones through every bus position and drives all-ones and alternating words. It also changes the select on every cycle. Each scan-input check is made between edges, so a path gated by the raw select instead of the registered mode is exposed.

// File: rtl/tbmux_pkg.sv
// Package: shared mode encoding for the ADC test bus multiplexer.
// Assumes: the select encoding is fixed at two bits.
package tbmux_pkg;
    typedef enum logic [1:0] {
        TB_IDLE = 2'b00,
        TB_FULL = 2'b01,
        TB_SUB  = 2'b10,
        TB_SCAN = 2'b11
    } tb_mode_e;
endpackage

// File: rtl/tbmux_mode_reg.sv
// Module: holds the bus mode sampled at the last clock edge.
// Assumes: synchronous active-low reset, reset mode is idle.
module tbmux_mode_reg
    import tbmux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    output tb_mode_e   mode_q
);
    // Capture the requested mode on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= TB_IDLE;
        else        mode_q <= tb_mode_e'(mode_sel);
    end
endmodule

// File: rtl/tbmux_out_stage.sv
// Module: selects one of the packed payload words and registers it onto the bus.
// Assumes: payload words are already packed to bus width by the parent.
module tbmux_out_stage
    import tbmux_pkg::*;
#(
    parameter int BUS_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic [BUS_W-1:0] full_word,
    input  logic [BUS_W-1:0] sub_word,
    input  logic [BUS_W-1:0] scan_word,
    output logic [BUS_W-1:0] bus_q
);
    logic [BUS_W-1:0] bus_d;

    // Pick the payload named by the raw select.
    always_comb begin
        unique case (tb_mode_e'(sel))
            TB_FULL: bus_d = full_word;
            TB_SUB:  bus_d = sub_word;
            TB_SCAN: bus_d = scan_word;
            default: bus_d = '0;
        endcase
    end

    // Register the selected payload onto the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |=> (bus_q == '0));
    p_full_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01) |=> (bus_q == $past(full_word)));
    p_sub_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10) |=> (bus_q == $past(sub_word)));
    p_scan_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |=> (bus_q == $past(scan_word)));
endmodule

// File: rtl/tbmux_scan_route.sv
// Module: forwards the incoming test bus to the scan inputs while in scan mode.
// Assumes: the mode input is registered, so the path changes only at edges.
module tbmux_scan_route
    import tbmux_pkg::*;
#(
    parameter int BUS_W = 14
) (
    input  tb_mode_e         mode_q,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] chain_in
);
    // Gate each bus bit onto its scan chain input.
    for (genvar i = 0; i < BUS_W; i++) begin : g_lane
        assign chain_in[i] = (mode_q == TB_SCAN) & bus_in[i];
    end
endmodule

// File: rtl/tbmux_top.sv
// Module: ADC test bus multiplexer top; packs the payloads and wires the stages.
// Assumes: RES_W + 2 equals the bus width and the sub-code widths sum to it.
module tbmux_top
    import tbmux_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int CRS_W = 4,
    parameter int MID_W = 4,
    parameter int FIN_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_sel,
    input  logic [RES_W-1:0]   conv_result,
    input  logic               under_flag,
    input  logic               over_flag,
    input  logic [CRS_W-1:0]   coarse_code,
    input  logic [MID_W-1:0]   mid_code,
    input  logic [FIN_W-1:0]   fine_code,
    input  logic [RES_W+1:0]   chain_out,
    input  logic [RES_W+1:0]   tbus_in,
    output logic [RES_W+1:0]   tbus_out,
    output logic [RES_W+1:0]   chain_in
);
    localparam int BUS_W = RES_W + 2;
    localparam int SUB_W = CRS_W + MID_W + FIN_W;

    tb_mode_e         mode_q;
    logic [BUS_W-1:0] full_word;
    logic [BUS_W-1:0] sub_word;
    logic [SUB_W-1:0] sub_raw;

    // Pack the result word with the range flags on top.
    assign full_word = {over_flag, under_flag, conv_result};
    // Pack the sub-converter codes, coarse uppermost.
    assign sub_raw   = {coarse_code, mid_code, fine_code};
    assign sub_word  = BUS_W'(sub_raw);

    tbmux_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .mode_q   (mode_q)
    );

    tbmux_out_stage #(.BUS_W(BUS_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (mode_sel),
        .full_word (full_word),
        .sub_word  (sub_word),
        .scan_word (chain_out),
        .bus_q     (tbus_out)
    );

    tbmux_scan_route #(.BUS_W(BUS_W)) u_scan (
        .mode_q   (mode_q),
        .bus_in   (tbus_in),
        .chain_in (chain_in)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (tbus_out == '0 && chain_in == '0));
    p_scan_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) != 2'b11) |-> (chain_in == '0));
    p_scan_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) == 2'b11) |-> (chain_in == tbus_in));
endmodule

// File: tb/tbmux_top_test.sv
module tbmux_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = '0;
    logic [11:0] conv_result = '0;
    logic        under_flag = 1'b0;
    logic        over_flag = 1'b0;
    logic [3:0]  coarse_code = '0;
    logic [3:0]  mid_code = '0;
    logic [5:0]  fine_code = '0;
    logic [13:0] chain_out = '0;
    logic [13:0] tbus_in = '0;
    logic [13:0] tbus_out;
    logic [13:0] chain_in;

    int total = 0;
    int bad = 0;
    logic [1:0] prev_mode = 2'b00;

    typedef struct {
        logic [13:0] exp_bus;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    tbmux_top uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .conv_result(conv_result), .under_flag(under_flag), .over_flag(over_flag),
        .coarse_code(coarse_code), .mid_code(mid_code), .fine_code(fine_code),
        .chain_out(chain_out), .tbus_in(tbus_in),
        .tbus_out(tbus_out), .chain_in(chain_in)
    );

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected bus word.
    task automatic drive(input logic [1:0] m, input logic [11:0] r, input logic u, input logic o,
                         input logic [3:0] c, input logic [3:0] md, input logic [5:0] f,
                         input logic [13:0] so, input logic [13:0] ti, input string tag);
        item_t it;
        @(negedge clk);
        mode_sel = m; conv_result = r; under_flag = u; over_flag = o;
        coarse_code = c; mid_code = md; fine_code = f; chain_out = so; tbus_in = ti;
        case (m)
            2'b01:   it.exp_bus = {o, u, r};
            2'b10:   it.exp_bus = {c, md, f};
            2'b11:   it.exp_bus = so;
            default: it.exp_bus = '0;
        endcase
        it.tag = tag;
        sbq.push_back(it);
        #1;
        // R7: the path follows the mode registered at the last edge, not the new select.
        check("R7 scan input gating", chain_in, (prev_mode == 2'b11) ? ti : 14'h0);
        prev_mode = m;
    endtask

    // Monitor: compares the bus shortly after each edge against the queue.
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(it.tag, tbus_out, it.exp_bus);
        end
    end

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        // R1: reset with busy inputs, including scan select.
        mode_sel = 2'b11; chain_out = 14'h3FFF; tbus_in = 14'h3FFF; conv_result = 12'hFFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset bus", tbus_out, 14'h0);
        check("R1 reset scan inputs", chain_in, 14'h0);
        @(negedge clk);
        rst_n = 1'b1;
        mode_sel = 2'b00;
        @(posedge clk);
        #1;
        sbq.delete();
        prev_mode = 2'b00;

        // R2: idle gives zero despite active data.
        drive(2'b00, 12'hABC, 1, 1, 4'hF, 4'hF, 6'h3F, 14'h3FFF, 14'h1234, "R2 idle");
        // R3: full result, flags in top bits.
        drive(2'b01, 12'hABC, 0, 1, 4'h1, 4'h2, 6'h03, 14'h0, 14'h0, "R3 overflow");
        drive(2'b01, 12'h000, 1, 0, 4'h1, 4'h2, 6'h03, 14'h0, 14'h0, "R3 underflow");
        drive(2'b01, 12'hFFF, 1, 1, 4'h0, 4'h0, 6'h00, 14'h0, 14'h0, "R3 all ones");
        for (int i = 0; i < 12; i++)
            drive(2'b01, 12'(1 << i), 0, 0, 4'h0, 4'h0, 6'h0, 14'h0, 14'h0, "R3 walking one");
        // R4: sub-codes, boundaries.
        drive(2'b10, 12'h0, 0, 0, 4'h8, 4'h0, 6'h00, 14'h0, 14'h0, "R4 coarse msb");
        drive(2'b10, 12'h0, 0, 0, 4'h0, 4'h1, 6'h20, 14'h0, 14'h0, "R4 mid lsb and fine msb");
        drive(2'b10, 12'h0, 0, 0, 4'h1, 4'h8, 6'h01, 14'h0, 14'h0, "R4 field edges");
        drive(2'b10, 12'hFFF, 1, 1, 4'hA, 4'h5, 6'h2A, 14'h0, 14'h0, "R4 alternating");
        // R5 and R7: scan traffic, walking ones in both directions.
        for (int i = 0; i < 14; i++)
            drive(2'b11, 12'h0, 0, 0, 4'h0, 4'h0, 6'h0, 14'(1 << i), 14'(1 << (13 - i)), "R5 scan walking");
        drive(2'b11, 12'h0, 0, 0, 4'h0, 4'h0, 6'h0, 14'h2AAA, 14'h1555, "R5 scan pattern");
        // R6 and R7: select changes every cycle, scan path must close and reopen on edges.
        lf = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(2'(k), lf[11:0], lf[12], lf[13], lf[3:0], lf[7:4], lf[15:10],
                  {lf[13:0]} ^ 14'h1F0F, lf[15:2], "R6 mode switching");
        end
        drive(2'b00, 12'h0, 0, 0, 4'h0, 4'h0, 6'h0, 14'h0, 14'h3FFF, "R2 return to idle");
        drive(2'b00, 12'h0, 0, 0, 4'h0, 4'h0, 6'h0, 14'h0, 14'h3FFF, "R2 idle hold");
        repeat (3) @(posedge clk);
        #2;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule